// File: doc/BRIEF.md
# Memory Self-Test Sequencer

This block runs a built-in test of an external memory over a plain request/valid command port. Software programs a control word, a 32-bit count of bursts (as two 16-bit halves) and then pulses a start bit. The sequencer issues a pass of write commands or a pass of read commands. Each access can be a single word or part of a burst of up to 255 words. The word address starts at 0 and advances by one for every word, so consecutive bursts follow each other with no gap.

Write data comes from one of four generators: three fixed words and one counter that starts at zero on every run. During a read pass, the same generator runs again against the returned data. A saturating counter records each mismatch. A done flag rises once every command has been accepted and, on a read pass, every read word has come back. Writing the same settings and then reading them back therefore reports zero mismatches.

The memory side holds `mem_req_o` and its address and data steady until `mem_gnt_i`. Read data returns in order with `mem_rvalid_i`, at least one cycle after the grant.

Top module: `mem_bist_engine`

## Requirements
- R1: While control bit 0 (test enable) is 0, a start write is ignored. No request is issued, and busy and done stay 0.
- R2: With control bit 1 = 0 (single access), a run issues exactly N word commands, where N is the burst count. The addresses are 0, 1, 2 and so on.
- R3: With control bit 1 = 1 (burst), a run issues N × L words at consecutive addresses from 0. L is control bits 15:8, and an L of 0 counts as 1.
- R4: Control bit 2 selects the pass: 0 issues writes (`mem_we_o` = 1) and 1 issues reads (`mem_we_o` = 0).
- R5: Control bits 5:4 select the write data. Code 0 gives 32'hAAAA5555, code 1 gives 32'hFFFFFFFF and code 2 gives 32'hA5A55A5A.
- R6: Pattern code 3 gives the word index, starting at 0 on every start. A read pass after a write pass with the same settings counts no mismatches.
- R7: The burst count is register 1 (bits 15:0) and register 2 (bits 31:16), and both read back as written. A count of 0 finishes the run with no command.
- R8: Writing a 1 to bit 0 of register 3 starts one run. A start written while a run is busy is ignored.
- R9: During a read pass, each returned word that differs from the regenerated pattern adds one to the error count. The count reads as register 4 (bits 15:0) and register 5 (bits 30:16).
- R10: The error count saturates at its all-ones value and does not wrap.
- R11: Register 6 bit 0 and `done_o` set when a run completes. On a read pass that means after the last read word has returned. A new start clears both done and the error count.
- R12: While a request waits for its grant, the request, address, write flag and write data stay stable.
- R13: Writes to registers 0, 1 and 2 are ignored while a run is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 3 | Register write address |
| reg_wdata_i | input | 16 | Register write data |
| reg_raddr_i | input | 3 | Register read address |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| mem_req_o | output | 1 | Memory command request |
| mem_we_o | output | 1 | 1 = write command, 0 = read command |
| mem_addr_o | output | ADDR_W | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Command accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run completed |

## Verification
During a read pass, a new command can be granted in the same cycle that an earlier read word returns. The outstanding-word count must then both rise and fall, while the mismatch counter updates on the returned word. The bench provokes this by granting at a steady rate with a one-cycle read latency, so issue and return overlap for most of every read burst. A second overlap comes from software register writes that land while the run is busy. A behavioural model tracks the outstanding words, the return index and the expected error count on its own. It is compared with the request, address, data, busy and done outputs on every cycle, and with the error registers when each run ends.

// File: rtl/bist_pkg.sv
package bist_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 16;
  localparam int CNT_W  = 32;
  localparam int DAT_W  = 32;
  localparam int LEN_W  = 8;

  typedef enum logic [REG_AW-1:0] {
    REG_CTRL   = 3'd0,
    REG_CNT_LO = 3'd1,
    REG_CNT_HI = 3'd2,
    REG_START  = 3'd3,
    REG_ERR_LO = 3'd4,
    REG_ERR_HI = 3'd5,
    REG_STAT   = 3'd6
  } reg_addr_e;

  typedef enum logic [1:0] {
    PAT_ALT   = 2'd0,
    PAT_ONES  = 2'd1,
    PAT_NIB   = 2'd2,
    PAT_INCR  = 2'd3
  } pat_sel_e;

  localparam logic [DAT_W-1:0] WORD_ALT  = 32'hAAAA5555;
  localparam logic [DAT_W-1:0] WORD_ONES = 32'hFFFFFFFF;
  localparam logic [DAT_W-1:0] WORD_NIB  = 32'hA5A55A5A;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [1:0]       pat;
    logic             rd;
    logic             burst;
    logic             mode;
  } cfg_t;
endpackage

// File: rtl/bist_pattern.sv
module bist_pattern
  import bist_pkg::*;
(
  input  logic [1:0]       sel_i,
  input  logic [DAT_W-1:0] idx_i,
  output logic [DAT_W-1:0] data_o
);
  always_comb begin
    unique case (pat_sel_e'(sel_i))
      PAT_ALT:  data_o = WORD_ALT;
      PAT_ONES: data_o = WORD_ONES;
      PAT_NIB:  data_o = WORD_NIB;
      default:  data_o = idx_i;
    endcase
  end
endmodule

// File: rtl/bist_regs.sv
module bist_regs
  import bist_pkg::*;
#(
  parameter int ERR_W = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] waddr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic [REG_AW-1:0] raddr_i,
  output logic [REG_DW-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [ERR_W-1:0]  err_i,
  output cfg_t              cfg_o,
  output logic [CNT_W-1:0]  burst_cnt_o,
  output logic              start_o
);
  localparam int EXT_W = 2 * REG_DW;

  logic [REG_DW-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [EXT_W-1:0]  err_ext;
  logic              cfg_wr;

  assign cfg_wr = we_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
    end else if (cfg_wr) begin
      case (reg_addr_e'(waddr_i))
        REG_CTRL:   ctrl_q <= wdata_i;
        REG_CNT_LO: cnt_q[REG_DW-1:0] <= wdata_i;
        REG_CNT_HI: cnt_q[CNT_W-1:REG_DW] <= wdata_i;
        default: ;
      endcase
    end
  end

  assign cfg_o = '{len:   ctrl_q[15:8],
                   pat:   ctrl_q[5:4],
                   rd:    ctrl_q[2],
                   burst: ctrl_q[1],
                   mode:  ctrl_q[0]};
  assign burst_cnt_o = cnt_q;

  // single-cycle by construction: one strobe per write
  assign start_o = we_i && (reg_addr_e'(waddr_i) == REG_START) && wdata_i[0]
                   && ctrl_q[0] && !busy_i;

  assign err_ext = {{(EXT_W-ERR_W){1'b0}}, err_i};

  always_comb begin
    case (reg_addr_e'(raddr_i))
      REG_CTRL:   rdata_o = ctrl_q;
      REG_CNT_LO: rdata_o = cnt_q[REG_DW-1:0];
      REG_CNT_HI: rdata_o = cnt_q[CNT_W-1:REG_DW];
      REG_ERR_LO: rdata_o = err_ext[REG_DW-1:0];
      REG_ERR_HI: rdata_o = err_ext[EXT_W-1:REG_DW];
      REG_STAT:   rdata_o = {{(REG_DW-2){1'b0}}, busy_i, done_i};
      default:    rdata_o = '0;
    endcase
  end

  // R13
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(ctrl_q) && $stable(cnt_q)));
endmodule

// File: rtl/bist_seq.sv
module bist_seq
  import bist_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OUT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              burst_i,
  input  logic              rd_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [CNT_W-1:0]  burst_cnt_i,
  input  logic              gnt_i,
  input  logic              rvalid_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DAT_W-1:0]  idx_o,
  output logic              busy_o,
  output logic              done_o
);
  logic             busy_q, issued_q, done_q;
  logic [LEN_W-1:0] beat_q;
  logic [CNT_W-1:0] burst_q;
  logic [DAT_W-1:0] idx_q;
  logic [OUT_W-1:0] out_q;
  logic [LEN_W-1:0] beat_last;
  logic             fire, rd_fire, rd_ret, last_beat, last_burst, finish;

  assign beat_last  = (burst_i && len_i != '0) ? len_i - 1'b1 : '0;
  assign req_o      = busy_q && !issued_q;
  assign fire       = req_o && gnt_i;
  assign rd_fire    = fire && rd_i;
  assign rd_ret     = busy_q && rd_i && rvalid_i;
  assign last_beat  = beat_q == beat_last;
  assign last_burst = burst_q == burst_cnt_i - 1'b1;
  assign finish     = busy_q && issued_q && (out_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      issued_q <= 1'b0;
      done_q   <= 1'b0;
      beat_q   <= '0;
      burst_q  <= '0;
      idx_q    <= '0;
      out_q    <= '0;
    end else if (start_i) begin
      busy_q   <= 1'b1;
      issued_q <= (burst_cnt_i == '0);
      done_q   <= 1'b0;
      beat_q   <= '0;
      burst_q  <= '0;
      idx_q    <= '0;
      out_q    <= '0;
    end else if (busy_q) begin
      if (fire) begin
        idx_q <= idx_q + 1'b1;
        if (last_beat) begin
          beat_q <= '0;
          if (last_burst) issued_q <= 1'b1;
          else            burst_q  <= burst_q + 1'b1;
        end else begin
          beat_q <= beat_q + 1'b1;
        end
      end
      // issue and return may coincide
      case ({rd_fire, rd_ret})
        2'b10:   out_q <= out_q + 1'b1;
        2'b01:   out_q <= out_q - 1'b1;
        default: ;
      endcase
      if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign addr_o = idx_q[ADDR_W-1:0];
  assign idx_o  = idx_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  // R1
  req_needs_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> mode_i);
  // R11
  ret_has_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ret |-> (out_q != '0));
  // R11
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !req_o);
  // R11
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fire && !rd_ret |-> (out_q != {OUT_W{1'b1}}));
endmodule

// File: rtl/bist_check.sv
module bist_check
  import bist_pkg::*;
#(
  parameter int ERR_W = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             en_i,
  input  logic [1:0]       pat_i,
  input  logic             rvalid_i,
  input  logic [DAT_W-1:0] rdata_i,
  output logic [ERR_W-1:0] err_o
);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  logic [DAT_W-1:0] rcv_q, exp_data;
  logic [ERR_W-1:0] err_q;
  logic             take;

  bist_pattern u_exp (
    .sel_i  (pat_i),
    .idx_i  (rcv_q),
    .data_o (exp_data)
  );

  assign take = en_i && rvalid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcv_q <= '0;
      err_q <= '0;
    end else if (start_i) begin
      rcv_q <= '0;
      err_q <= '0;
    end else if (take) begin
      rcv_q <= rcv_q + 1'b1;
      if (rdata_i != exp_data && err_q != ERR_MAX) err_q <= err_q + 1'b1;
    end
  end

  assign err_o = err_q;

  // R10
  err_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && err_q == ERR_MAX) |=> (err_q == ERR_MAX));
  // R9
  err_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (err_q - $past(err_q) <= 1));
endmodule

// File: rtl/mem_bist_engine.sv
module mem_bist_engine
  import bist_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int ERR_W  = 31,
  parameter int OUT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_waddr_i,
  input  logic [15:0]       reg_wdata_i,
  input  logic [2:0]        reg_raddr_i,
  output logic [15:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              busy_o,
  output logic              done_o
);
  cfg_t             cfg;
  logic [CNT_W-1:0] burst_cnt;
  logic [DAT_W-1:0] idx;
  logic [ERR_W-1:0] err;
  logic             start, busy, done;

  bist_regs #(.ERR_W(ERR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .waddr_i     (reg_waddr_i),
    .wdata_i     (reg_wdata_i),
    .raddr_i     (reg_raddr_i),
    .rdata_o     (reg_rdata_o),
    .busy_i      (busy),
    .done_i      (done),
    .err_i       (err),
    .cfg_o       (cfg),
    .burst_cnt_o (burst_cnt),
    .start_o     (start)
  );

  bist_seq #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .mode_i      (cfg.mode),
    .burst_i     (cfg.burst),
    .rd_i        (cfg.rd),
    .len_i       (cfg.len),
    .burst_cnt_i (burst_cnt),
    .gnt_i       (mem_gnt_i),
    .rvalid_i    (mem_rvalid_i),
    .req_o       (mem_req_o),
    .addr_o      (mem_addr_o),
    .idx_o       (idx),
    .busy_o      (busy),
    .done_o      (done)
  );

  bist_pattern u_wpat (
    .sel_i  (cfg.pat),
    .idx_i  (idx),
    .data_o (mem_wdata_o)
  );

  bist_check #(.ERR_W(ERR_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .en_i     (busy && cfg.rd),
    .pat_i    (cfg.pat),
    .rvalid_i (mem_rvalid_i),
    .rdata_i  (mem_rdata_i),
    .err_o    (err)
  );

  assign mem_we_o = !cfg.rd;
  assign busy_o   = busy;
  assign done_o   = done;

  // R12
  hold_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)
                                   && $stable(mem_we_o) && $stable(mem_wdata_o)));
  // R8
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy);
endmodule

// File: tb/mem_bist_engine_bench.sv
module mem_bist_engine_bench;
  localparam int ADDR_W = 24;
  localparam longint MAX_MAIN = (64'd1 << 31) - 1;
  localparam longint MAX_SAT  = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_waddr = '0;
  logic [15:0] reg_wdata = '0;
  logic [2:0]  reg_raddr = '0;
  logic [15:0] reg_rdata, sat_rdata;
  logic        mem_req, mem_we, s_req, s_we, s_busy, s_done;
  logic [ADDR_W-1:0] mem_addr, s_addr;
  logic [31:0] mem_wdata, s_wdata;
  logic        mem_gnt = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        busy, done;

  int n_chk = 0, n_fail = 0;
  bit stall_en = 1'b0;
  int inj_addr = -1;
  int n_xfer = 0;
  int cyc = 0;
  logic [31:0] mem [256];

  // reference model state
  bit     m_busy = 0, m_done = 0;
  logic [15:0] m_ctrl = '0, m_lo = '0, m_hi = '0;
  longint m_total = 0, m_idx = 0, m_rcv = 0, m_out = 0, m_err = 0, m_err_sat = 0;
  logic [1:0] m_pat = '0;
  bit     m_rd = 0;

  always #2.5 clk = ~clk;

  mem_bist_engine #(.ADDR_W(ADDR_W)) u_mem_bist_engine (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_waddr_i(reg_waddr),
    .reg_wdata_i(reg_wdata), .reg_raddr_i(reg_raddr), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done));

  mem_bist_engine #(.ADDR_W(ADDR_W), .ERR_W(3)) u_mem_bist_engine_sat (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_waddr_i(reg_waddr),
    .reg_wdata_i(reg_wdata), .reg_raddr_i(reg_raddr), .reg_rdata_o(sat_rdata),
    .mem_req_o(s_req), .mem_we_o(s_we), .mem_addr_o(s_addr),
    .mem_wdata_o(s_wdata), .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .busy_o(s_busy), .done_o(s_done));

  function automatic logic [31:0] pat_word(logic [1:0] sel, longint i);
    case (sel)
      2'd0: return 32'hAAAA5555;
      2'd1: return 32'hFFFFFFFF;
      2'd2: return 32'hA5A55A5A;
      default: return i[31:0];
    endcase
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rvalid <= 1'b0;
    if (mem_req && mem_gnt) begin
      n_xfer <= n_xfer + 1;
      if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
      else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[7:0]] ^ ((int'(mem_addr) == inj_addr) ? 32'h1 : 32'h0);
      end
    end
  end

  always @(negedge clk) mem_gnt <= stall_en ? ((cyc % 3) != 1) : 1'b1;

  // behavioural reference, advanced on every edge
  always @(posedge clk) begin
    if (rst_n) begin
      bit req_now, fin;
      req_now = m_busy && (m_idx < m_total);
      fin = m_busy && (m_idx >= m_total) && (m_out == 0);
      if (m_busy) begin
        if (req_now && mem_gnt) begin
          m_idx++;
          if (m_rd) m_out++;
        end
        if (m_rd && mem_rvalid) begin
          if (mem_rdata != pat_word(m_pat, m_rcv)) begin
            if (m_err < MAX_MAIN) m_err++;
            if (m_err_sat < MAX_SAT) m_err_sat++;
          end
          m_rcv++;
          m_out--;
        end
        if (fin) begin m_busy = 0; m_done = 1; end
      end else if (reg_we) begin
        if (reg_waddr == 3'd0) m_ctrl = reg_wdata;
        if (reg_waddr == 3'd1) m_lo = reg_wdata;
        if (reg_waddr == 3'd2) m_hi = reg_wdata;
        if (reg_waddr == 3'd3 && reg_wdata[0] && m_ctrl[0]) begin
          longint wpb;
          wpb = (m_ctrl[1] && m_ctrl[15:8] != 0) ? longint'(m_ctrl[15:8]) : 1;
          m_total = longint'({m_hi, m_lo}) * wpb;
          m_busy = 1; m_done = 0; m_idx = 0; m_rcv = 0; m_out = 0;
          m_err = 0; m_err_sat = 0;
          m_pat = m_ctrl[5:4]; m_rd = m_ctrl[2];
        end
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      bit er;
      er = m_busy && (m_idx < m_total);
      chk(mem_req == er, "R2 req", mem_req, er);
      chk(busy == m_busy, "R8 busy", busy, m_busy);
      chk(done == m_done, "R11 done", done, m_done);
      if (er) begin
        chk(mem_addr == m_idx[ADDR_W-1:0], "R3 addr", mem_addr, m_idx);
        chk(mem_we == !m_rd, "R4 we", mem_we, !m_rd);
        if (!m_rd) chk(mem_wdata == pat_word(m_pat, m_idx), "R5 wdata", mem_wdata, pat_word(m_pat, m_idx));
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d, output logic [15:0] ds);
    @(negedge clk);
    reg_raddr = a;
    #1;
    d = reg_rdata; ds = sat_rdata;
  endtask

  function automatic logic [15:0] ctl(bit mode, bit bst, bit rdp, logic [1:0] p, logic [7:0] len);
    return {len, 2'b00, p, 1'b0, rdp, bst, mode};
  endfunction

  task automatic run(logic [15:0] c, logic [15:0] cnt);
    wr(3'd0, c); wr(3'd1, cnt); wr(3'd2, 16'h0);
    n_xfer = 0;
    wr(3'd3, 16'h1);
    for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
    chk(done == 1'b1, "R11 run end", done, 1);
  endtask

  task automatic check_err(string req, longint exp, longint exp_sat);
    logic [15:0] lo, hi, slo, shi;
    rd(3'd4, lo, slo);
    rd(3'd5, hi, shi);
    chk({hi, lo} == exp, req, {hi, lo}, exp);
    chk(slo == exp_sat, "R10 sat", slo, exp_sat);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v, vs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v, vs);
      chk(v == 0, "R11 reset regs", v, 0);
    end
    // R1: test mode off
    wr(3'd0, ctl(0, 0, 0, 2'd0, 8'd0)); wr(3'd1, 16'd4);
    n_xfer = 0;
    wr(3'd3, 16'h1);
    repeat (8) @(negedge clk);
    chk(busy == 0 && done == 0 && n_xfer == 0, "R1 ignored", n_xfer, 0);
    // R2 single write/read, pattern 0
    stall_en = 1'b1;
    run(ctl(1, 0, 0, 2'd0, 8'd0), 16'd6);
    chk(n_xfer == 6, "R2 count", n_xfer, 6);
    run(ctl(1, 0, 1, 2'd0, 8'd0), 16'd6);
    check_err("R9 clean", 0, 0);
    // R6 incrementing burst, twice read
    run(ctl(1, 1, 0, 2'd3, 8'd4), 16'd3);
    chk(n_xfer == 12, "R3 burst count", n_xfer, 12);
    run(ctl(1, 1, 1, 2'd3, 8'd4), 16'd3);
    check_err("R6 zero", 0, 0);
    run(ctl(1, 1, 1, 2'd3, 8'd4), 16'd3);
    check_err("R6 restart", 0, 0);
    inj_addr = 5;
    run(ctl(1, 1, 1, 2'd3, 8'd4), 16'd3);
    check_err("R9 one", 1, 1);
    inj_addr = -1;
    // R5 other fixed words
    run(ctl(1, 0, 0, 2'd1, 8'd0), 16'd4);
    run(ctl(1, 0, 1, 2'd1, 8'd0), 16'd4);
    check_err("R5 ones", 0, 0);
    run(ctl(1, 0, 0, 2'd2, 8'd0), 16'd4);
    run(ctl(1, 0, 1, 2'd2, 8'd0), 16'd4);
    check_err("R5 nib", 0, 0);
    // R3 length 0 counts as 1
    stall_en = 1'b0;
    run(ctl(1, 1, 0, 2'd0, 8'd0), 16'd3);
    chk(n_xfer == 3, "R3 len zero", n_xfer, 3);
    // R7 zero count
    run(ctl(1, 0, 0, 2'd0, 8'd0), 16'd0);
    chk(n_xfer == 0, "R7 zero", n_xfer, 0);
    wr(3'd2, 16'h0001); wr(3'd1, 16'hBEEF);
    rd(3'd2, v, vs); chk(v == 16'h0001, "R7 hi", v, 1);
    rd(3'd1, v, vs); chk(v == 16'hBEEF, "R7 lo", v, 16'hBEEF);
    wr(3'd2, 16'h0);
    // R10 many mismatches, saturating copy
    stall_en = 1'b1;
    run(ctl(1, 0, 0, 2'd0, 8'd0), 16'd10);
    run(ctl(1, 0, 1, 2'd1, 8'd0), 16'd10);
    check_err("R9 ten", 10, 7);
    // R11 new start clears count
    wr(3'd0, ctl(1, 0, 0, 2'd0, 8'd0));
    wr(3'd3, 16'h1);
    chk(done == 0, "R11 clear done", done, 0);
    for (int i = 0; i < 500 && !done; i++) @(negedge clk);
    check_err("R11 clear err", 0, 0);
    // R13 / R8 writes during busy
    wr(3'd0, ctl(1, 0, 0, 2'd3, 8'd0)); wr(3'd1, 16'd30);
    n_xfer = 0;
    wr(3'd3, 16'h1);
    wr(3'd0, 16'h00F0);
    wr(3'd1, 16'd2);
    wr(3'd3, 16'h1);
    rd(3'd0, v, vs); chk(v == ctl(1, 0, 0, 2'd3, 8'd0), "R13 ctrl kept", v, ctl(1, 0, 0, 2'd3, 8'd0));
    rd(3'd1, v, vs); chk(v == 16'd30, "R13 cnt kept", v, 30);
    for (int i = 0; i < 500 && !done; i++) @(negedge clk);
    chk(n_xfer == 30, "R8 restart ignored", n_xfer, 30);
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule